// File: doc/BRIEF.md
# Capture-Reloaded 16-bit Up-Counter with Compare Match

This block is a 16-bit up-counter whose count rate comes from the system clock through a prescaler that divides by powers of four. A run bit gates the counting. A mode bit picks one of two behaviours for the 16-bit companion register. In reload mode, an event on one chosen capture channel either loads the counter from that register or clears the counter. The prescaler does not gate this event, and a wrap from FFFFh sets the flag. In compare mode, the register holds a compare value. A counting tick taken while the counter equals it sets the flag and may clear the counter.

Software writes the counter, the companion register and the flag through a byte-wide write port. The counter value and one sticky event flag are driven out for the surrounding logic.

Top module: `capreload_timer`

## Requirements
- R1: During reset and right after it, `count` is 0000h, `flag` is 0, and the companion register is 0000h.
- R2: The counter takes one step only on a prescaler tick. With `run_en` held high, a tick comes once every 4^`div_sel` cycles, and the first comes 4^`div_sel` cycles after `run_en` rises. While `run_en` is low the prescaler stays cleared and the counter does not count.
- R3: Without a load or clear, the counter wraps from FFFFh to 0000h. In reload mode (`cmp_mode`=0), that wrapping step sets `flag`.
- R4: A write with `wr_en`=1 targets the register named by `wr_addr`. Address 0 is the counter low byte and 1 the counter high byte. Address 2 is the companion low byte, 3 the companion high byte, and 4 the flag (from `wr_data[0]`). Other addresses have no effect. A counter byte write replaces that byte on the next edge. In that cycle it suppresses counting, loading, clearing and flag setting, and the other byte holds.
- R5: In reload mode with `reload_en`=1, `reload_src` codes 0, 1 and 2 select `cap_evt[0]`, `cap_evt[1]` and `cap_evt[2]`. An event on the selected bit loads the counter from the companion register on the next edge, whatever `run_en` and the prescaler are doing. Code 3 selects no channel.
- R6: In reload mode with `reload_en`=0, capture events leave the counter untouched.
- R7: In reload mode with `reload_en`=1 and `clr_on_cap`=1, a selected capture event clears the counter to 0000h instead of loading it.
- R8: In compare mode (`cmp_mode`=1), a prescaler tick taken while the counter equals the companion register sets `flag`. Capture events have no effect on the counter in this mode.
- R9: In compare mode with `clr_on_cmp`=1, the tick that produces a match clears the counter to 0000h instead of incrementing it.
- R10: `flag` is sticky and falls only when 0 is written to address 4. If a hardware set falls in the same cycle as that write, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Enables the prescaler and counting |
| div_sel | input | 3 | Prescaler select: divide by 4^div_sel |
| cmp_mode | input | 1 | 0: capture-reload mode, 1: compare mode |
| reload_en | input | 1 | Allows a capture event to load or clear the counter |
| reload_src | input | 2 | Capture channel select (3 = none) |
| clr_on_cap | input | 1 | Capture event clears rather than loads |
| clr_on_cmp | input | 1 | Compare match clears the counter |
| cap_evt | input | 3 | Single-cycle capture event per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| count | output | 16 | Current counter value |
| flag | output | 1 | Sticky wrap / compare-match flag |

## Verification
Directed sequences run each mode in isolation. In reload mode they step through every `reload_src` code with each capture bit, so a wrong channel mapping or an unintended response to code 3 shows up. Load is compared against clear, and enabled against disabled. A counter primed near FFFFh shows the wrap flag. Compare mode is run with a low compare value, once with clearing on and once with it off, so a miscounted period or a match taken on the wrong value is exposed. One edge pits a flag clear against a simultaneous match. A long random mix then changes mode, divide setting, capture bits and writes together, with high bytes often zero so that matches happen. Throughout it, the output is compared every cycle with a cycle-level model of the requirements. This catches priority and prescaler-phase errors that the directed cases do not reach.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Action the counter takes on the next edge when software is not writing it.
  typedef enum logic [1:0] {
    HW_HOLD  = 2'd0,
    HW_COUNT = 2'd1,
    HW_LOAD  = 2'd2,
    HW_CLEAR = 2'd3
  } hw_act_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  // Largest divide is 4^(2^DIV_W - 1), so this many bits are needed.
  localparam int PRE_W = 2 * ((1 << DIV_W) - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = ~({PRE_W{1'b1}} << (2 * div_sel));
    pre_d = run_en ? (pre_q + PRE_W'(1)) : '0;
    tick  = run_en && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end
endmodule

// File: rtl/tmr_trigsel.sv
module tmr_trigsel #(
  parameter int N_CAP = 3,
  parameter int SRC_W = 2
) (
  input  logic [N_CAP-1:0] cap_evt,
  input  logic [SRC_W-1:0] src,
  output logic             trig
);
  // Codes at or above N_CAP pick no channel.
  always_comb begin
    trig = 1'b0;
    for (int i = 0; i < N_CAP; i++) begin
      if (src == SRC_W'(i)) trig = cap_evt[i];
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     flag_set,
  output logic [CNT_W/DATA_W-1:0]  cnt_byte_wr,
  output logic [CNT_W-1:0]         reload_val,
  output logic                     flag
);
  localparam int NB        = CNT_W / DATA_W;
  localparam int FLAG_ADDR = 2 * NB;

  logic [NB-1:0]    rld_wr;
  logic [CNT_W-1:0] rld_q;
  logic [CNT_W-1:0] rld_d;
  logic             flag_wr;
  logic             flag_q;
  logic             flag_d;

  for (genvar b = 0; b < NB; b++) begin : g_dec
    assign cnt_byte_wr[b] = wr_en && (wr_addr == ADDR_W'(b));
    assign rld_wr[b]      = wr_en && (wr_addr == ADDR_W'(NB + b));
  end

  assign flag_wr = wr_en && (wr_addr == ADDR_W'(FLAG_ADDR));

  always_comb begin
    rld_d = rld_q;
    for (int b = 0; b < NB; b++) begin
      if (rld_wr[b]) rld_d[b*DATA_W +: DATA_W] = wr_data;
    end
    // A hardware event outranks a software write in the same cycle.
    if (flag_set)     flag_d = 1'b1;
    else if (flag_wr) flag_d = wr_data[0];
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (|rld_wr)            rld_q  <= rld_d;
      if (flag_set || flag_wr) flag_q <= flag_d;
    end
  end

  assign reload_val = rld_q;
  assign flag       = flag_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  hw_act_e                 act,
  input  logic [CNT_W-1:0]        reload_val,
  input  logic [CNT_W/DATA_W-1:0] byte_wr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [CNT_W-1:0]        count
);
  localparam int NB = CNT_W / DATA_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    unique case (act)
      HW_COUNT: cnt_d = cnt_q + CNT_W'(1);
      HW_LOAD:  cnt_d = reload_val;
      HW_CLEAR: cnt_d = '0;
      default:  cnt_d = cnt_q;
    endcase
    for (int b = 0; b < NB; b++) begin
      if (byte_wr[b]) cnt_d[b*DATA_W +: DATA_W] = wr_data;
    end
    cnt_en = (act != HW_HOLD) || (|byte_wr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/capreload_timer.sv
module capreload_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 3,
  parameter int N_CAP  = 3,
  parameter int SRC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              cmp_mode,
  input  logic              reload_en,
  input  logic [SRC_W-1:0]  reload_src,
  input  logic              clr_on_cap,
  input  logic              clr_on_cmp,
  input  logic [N_CAP-1:0]  cap_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              flag
);
  localparam int NB = CNT_W / DATA_W;

  logic [1:0]       rst_sync;
  logic             rst_q_n;
  logic             tick;
  logic             trig;
  logic [NB-1:0]    cnt_byte_wr;
  logic [CNT_W-1:0] reload_val;
  logic             flag_set;
  hw_act_e          act;

  // Reset: asserts at once, leaves on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  tmr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .run_en  (run_en),
    .div_sel (div_sel),
    .tick    (tick)
  );

  tmr_trigsel #(.N_CAP(N_CAP), .SRC_W(SRC_W)) u_sel (
    .cap_evt (cap_evt),
    .src     (reload_src),
    .trig    (trig)
  );

  tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .flag_set    (flag_set),
    .cnt_byte_wr (cnt_byte_wr),
    .reload_val  (reload_val),
    .flag        (flag)
  );

  // Hardware action: a software counter write wins, then capture, then ticks.
  always_comb begin
    act      = HW_HOLD;
    flag_set = 1'b0;
    if (!(|cnt_byte_wr)) begin
      if (!cmp_mode) begin
        if (reload_en && trig) begin
          act = clr_on_cap ? HW_CLEAR : HW_LOAD;
        end else if (tick) begin
          act      = HW_COUNT;
          flag_set = &count;
        end
      end else if (tick) begin
        flag_set = (count == reload_val);
        act      = (flag_set && clr_on_cmp) ? HW_CLEAR : HW_COUNT;
      end
    end
  end

  tmr_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .act        (act),
    .reload_val (reload_val),
    .byte_wr    (cnt_byte_wr),
    .wr_data    (wr_data),
    .count      (count)
  );
endmodule

// File: rtl/capreload_timer_chk.sv
module capreload_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 3,
  parameter int N_CAP  = 3,
  parameter int SRC_W  = 2
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              run_en,
  input logic [DIV_W-1:0]  div_sel,
  input logic              cmp_mode,
  input logic              reload_en,
  input logic [SRC_W-1:0]  reload_src,
  input logic              clr_on_cap,
  input logic              clr_on_cmp,
  input logic [N_CAP-1:0]  cap_evt,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  count,
  input logic              flag,
  input logic [CNT_W-1:0]  reload_val
);
  localparam int NB        = CNT_W / DATA_W;
  localparam int FLAG_ADDR = 2 * NB;

  logic cw;
  logic sel;
  always_comb begin
    cw  = wr_en && (int'(wr_addr) < NB);
    sel = 1'b0;
    for (int i = 0; i < N_CAP; i++) begin
      if (int'(reload_src) == i) sel = cap_evt[i];
    end
  end

  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!run_en && !cw && (cmp_mode || !(reload_en && sel))) |=> $stable(count));

  // R5
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!cmp_mode && reload_en && !clr_on_cap && sel && !cw) |=> (count == $past(reload_val)));

  // R7
  cap_clear_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!cmp_mode && reload_en && clr_on_cap && sel && !cw) |=> (count == '0));

  // R9
  cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmp_mode && clr_on_cmp && run_en && div_sel == '0 && count == reload_val && !cw)
    |=> (count == '0 && flag));

  // R4
  low_byte_wr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wr_addr == '0) |=> (count[DATA_W-1:0] == $past(wr_data)));

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flag && !(wr_en && wr_addr == ADDR_W'(FLAG_ADDR) && !wr_data[0])) |=> flag);
endmodule

bind capreload_timer capreload_timer_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .DIV_W(DIV_W), .N_CAP(N_CAP), .SRC_W(SRC_W)
) u_chk (.*);

// File: tb/capreload_timer_bench.sv
module capreload_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        run_en, cmp_mode, reload_en, clr_on_cap, clr_on_cmp, wr_en;
  logic [2:0]  div_sel, cap_evt, wr_addr;
  logic [1:0]  reload_src;
  logic [7:0]  wr_data;
  logic [15:0] count;
  logic        flag;

  logic [15:0] m_cnt, m_rld;
  logic        m_flag;
  logic [13:0] m_pre;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  capreload_timer u_capreload_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .div_sel(div_sel),
    .cmp_mode(cmp_mode), .reload_en(reload_en), .reload_src(reload_src),
    .clr_on_cap(clr_on_cap), .clr_on_cmp(clr_on_cmp), .cap_evt(cap_evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .flag(flag)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Reference model built from the requirements, advanced once per cycle.
  task automatic model_step();
    logic [13:0] mask;
    logic        tk, tr, cw, fs;
    mask = 14'((32'd1 << (2 * div_sel)) - 32'd1);
    tk = run_en && ((m_pre & mask) == mask);
    case (reload_src)
      2'd0: tr = cap_evt[0];
      2'd1: tr = cap_evt[1];
      2'd2: tr = cap_evt[2];
      default: tr = 1'b0;
    endcase
    cw = wr_en && (wr_addr < 3'd2);
    fs = 1'b0;
    if (cw) begin
      if (wr_addr == 3'd0) m_cnt[7:0] = wr_data;
      else                 m_cnt[15:8] = wr_data;
    end else if (!cmp_mode) begin
      if (reload_en && tr) m_cnt = clr_on_cap ? 16'h0 : m_rld;
      else if (tk) begin
        fs = (m_cnt == 16'hFFFF);
        m_cnt = m_cnt + 16'd1;
      end
    end else if (tk) begin
      fs = (m_cnt == m_rld);
      m_cnt = (fs && clr_on_cmp) ? 16'h0 : m_cnt + 16'd1;
    end
    if (fs) m_flag = 1'b1;
    else if (wr_en && wr_addr == 3'd4) m_flag = wr_data[0];
    if (wr_en && wr_addr == 3'd2) m_rld[7:0]  = wr_data;
    if (wr_en && wr_addr == 3'd3) m_rld[15:8] = wr_data;
    m_pre = run_en ? m_pre + 14'd1 : 14'd0;
  endtask

  // One cycle: model, edge, sample at the falling edge, drop one-shot inputs.
  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check("MODEL count", {16'h0, count}, {16'h0, m_cnt});
    check("MODEL flag", {31'h0, flag}, {31'h0, m_flag});
    wr_en   = 1'b0;
    cap_evt = 3'b000;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
  endtask

  task automatic cap(logic [2:0] c);
    cap_evt = c;
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    run_en = 0; div_sel = 0; cmp_mode = 0; reload_en = 0; reload_src = 0;
    clr_on_cap = 0; clr_on_cmp = 0; cap_evt = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    m_cnt = 0; m_rld = 0; m_flag = 0; m_pre = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1 count in reset", {16'h0, count}, 32'h0);
    check("R1 flag in reset", {31'h0, flag}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 count after reset", {16'h0, count}, 32'h0);

    // R5: channel mapping with load
    wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    reload_en = 1; reload_src = 2'd1;
    cap(3'b101);
    check("R5 unselected channels", {16'h0, count}, 32'h0);
    cap(3'b010);
    check("R5 load from companion", {16'h0, count}, 32'h1234);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    reload_src = 2'd2; cap(3'b100);
    check("R5 channel 2 load", {16'h0, count}, 32'h1234);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    reload_src = 2'd3; cap(3'b111);
    check("R5 code 3 selects none", {16'h0, count}, 32'h0);
    // R6: loads disabled
    reload_src = 2'd0; reload_en = 0; cap(3'b001);
    check("R6 reload disabled", {16'h0, count}, 32'h0);
    // R7: clear wins over load
    reload_en = 1; cap(3'b001);
    check("R7 setup load", {16'h0, count}, 32'h1234);
    clr_on_cap = 1; cap(3'b001);
    check("R7 clear on capture", {16'h0, count}, 32'h0);
    clr_on_cap = 0; reload_en = 0;

    // R3: wrap and flag
    wr(3'd0, 8'hFE); wr(3'd1, 8'hFF);
    run_en = 1; div_sel = 0;
    cyc();
    check("R3 before wrap", {16'h0, count}, 32'hFFFF);
    check("R3 no flag yet", {31'h0, flag}, 32'h0);
    cyc();
    check("R3 wrapped", {16'h0, count}, 32'h0);
    check("R3 wrap flag", {31'h0, flag}, 32'h1);
    run_en = 0;
    wr(3'd4, 8'h00);
    check("R10 software clear", {31'h0, flag}, 32'h0);

    // R2: prescaler divide by 4
    cyc();
    div_sel = 1; run_en = 1;
    repeat (8) cyc();
    check("R2 divide by 4", {16'h0, count}, 32'h2);
    run_en = 0;
    repeat (3) cyc();
    check("R2 halted", {16'h0, count}, 32'h2);
    div_sel = 0;

    // R8: compare match
    cmp_mode = 1;
    wr(3'd2, 8'h05); wr(3'd3, 8'h00);
    wr(3'd0, 8'h03);
    run_en = 1;
    cyc(); cyc();
    check("R8 reached compare", {16'h0, count}, 32'h5);
    check("R8 no flag before tick", {31'h0, flag}, 32'h0);
    cyc();
    check("R8 counts past match", {16'h0, count}, 32'h6);
    check("R8 match flag", {31'h0, flag}, 32'h1);
    run_en = 0; reload_en = 1;
    cap(3'b111);
    check("R8 capture ignored", {16'h0, count}, 32'h6);
    reload_en = 0;

    // R9: clear on compare; R10: set beats clear
    clr_on_cmp = 1;
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h05);
    run_en = 1;
    wr(3'd4, 8'h00);
    check("R9 clear on match", {16'h0, count}, 32'h0);
    check("R10 set beats clear", {31'h0, flag}, 32'h1);
    // R4: counter write during counting
    wr(3'd0, 8'hA5);
    check("R4 low byte write", {16'h0, count}, 32'h00A5);
    wr(3'd1, 8'h3C);
    check("R4 high byte write", {16'h0, count}, 32'h3CA5);
    run_en = 0; clr_on_cmp = 0;
    wr(3'd7, 8'hFF);
    check("R4 unused address", {16'h0, count}, 32'h3CA5);

    // Random mix checked against the model every cycle
    for (int i = 0; i < 6000; i++) begin
      if (i % 300 == 0) cmp_mode = $urandom_range(0, 1) == 1;
      if (i % 50 == 0) begin
        div_sel    = 3'($urandom_range(0, 2));
        reload_src = 2'($urandom_range(0, 3));
        reload_en  = $urandom_range(0, 3) != 0;
        clr_on_cap = $urandom_range(0, 2) == 0;
        clr_on_cmp = $urandom_range(0, 1) == 1;
      end
      run_en  = $urandom_range(0, 9) != 0;
      cap_evt = {$urandom_range(0, 19) == 0, $urandom_range(0, 19) == 0,
                 $urandom_range(0, 19) == 0};
      if ($urandom_range(0, 9) == 0) begin
        wr_en   = 1'b1;
        wr_addr = 3'($urandom_range(0, 5));
        wr_data = 8'($urandom_range(0, 255));
        if ((wr_addr == 3'd1 || wr_addr == 3'd3) && $urandom_range(0, 9) < 7)
          wr_data = 8'h00;
        if ((wr_addr == 3'd0 || wr_addr == 3'd2) && $urandom_range(0, 1) == 1)
          wr_data = 8'($urandom_range(0, 15));
      end
      cyc();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule